// File: doc/BRIEF.md
# DMA Channel Control Register Bank

This block is the software-visible control plane of a sixteen-channel DMA engine. Each channel has a private window of four words: a start address, an X (line) length, a Y (line count) length and a control word. Each channel also has a line-pitch word in a separate table. A set of shared bitmap registers sits above these. One reports which channels are running and cancels channels. One holds sticky completion flags. One masks those flags onto a single interrupt line. One selects looping operation.

Software programs a channel's length, pitch and control words first. It then writes the start address, and that write launches the channel: a one-cycle start pulse goes to the address generator. Completion events come back as input pulses. Each event raises a sticky flag, which software clears by writing a one. A write of ones to the running-channel register sends one-cycle cancel pulses. The register interface is single-cycle: a write is taken on the clock edge, and read data is a combinational function of the address.

Top module: `dma_regbank`

## Requirements
- R1: After reset every register reads zero, and every output is zero: start, cancel, configuration, loop flags and interrupt.
- R2: Channel c owns byte offsets c*0x10 + {0x0 address, 0x4 X length, 0x8 Y length, 0xC control}. The first three hold and return all 32 bits. The control word keeps bits 5:0, and its bits 31:6 read as zero. Each register drives its channel's configuration output.
- R3: Control bit 4 drives burst4_o[c], where 1 means bursts of four words. Control bit 5 drives dir_o[c].
- R4: The pitch register of channel c is at 0x100 + 4*c. It is 32 bits wide, and it reads back and drives width_o.
- R5: A write to channel c's address word gives start_o == (1<<c) in the following cycle only. A write to any other offset gives no start pulse.
- R6: The running register at 0x140 reads bit c = 1 from a launch of channel c. The bit clears when software writes a one to bit c, and that write also gives cancel_o[c] for one cycle. The bit also clears on a completion event of a channel that is not looping. A launch wins over a same-cycle completion.
- R7: The status register at 0x144 sets bit c on done_i[c]. The bit holds until a write of one to bit c clears it. A completion event wins over a same-cycle clear.
- R8: The enable register at 0x148 is read/write in bits 15:0. irq_o is high exactly when a status bit and its enable bit are both set.
- R9: The loop register at 0x150 holds all 32 bits. loop_o[c] is bit c AND bit c+16. A completion event on a looping channel leaves its running bit set.
- R10: Reads of unmapped or misaligned (addr[1:0] != 0) offsets return zero. Writes to them change no register and pulse nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe, taken on the clock edge |
| addr_i | input | 12 | Byte address of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| done_i | input | 16 | Per-channel completion event pulses |
| start_o | output | 16 | Per-channel launch pulses |
| cancel_o | output | 16 | Per-channel cancel pulses |
| addr_o | output | 512 | Start address of each channel, 32 bits per channel |
| xlen_o | output | 512 | X length of each channel |
| ylen_o | output | 512 | Y length of each channel |
| width_o | output | 512 | Line pitch of each channel |
| burst4_o | output | 16 | Burst-of-four select per channel |
| dir_o | output | 16 | Transfer direction per channel |
| loop_o | output | 16 | Loop mode per channel |
| irq_o | output | 1 | Combined interrupt |

## Verification
Directed sequences set up the cases that random traffic seldom hits. One has a clear and a completion on the same status bit in the same cycle, which shows whether set beats clear. Another sends completions to one looping and one non-looping channel, which shows whether the loop pair keeps a channel running. Writes to the gaps at 0x14C and 0x154, to the upper space and to misaligned addresses show that decoding is exact. A long random mix of writes across every field follows, with completion pulses overlapping the writes. After each cycle the start, cancel and interrupt outputs are compared against a register model. Periodic full read-back sweeps then separate errors in window decoding, in field masking and in the side effects of the bitmap registers.

// File: rtl/dma_regbank_pkg.sv
package dma_regbank_pkg;
  localparam int unsigned CH_STRIDE  = 16;
  localparam int unsigned WIDTH_BASE = 'h100;
  localparam int unsigned VALID_OFF  = 'h140;
  localparam int unsigned STS_OFF    = 'h144;
  localparam int unsigned EN_OFF     = 'h148;
  localparam int unsigned LOOP_OFF   = 'h150;
  localparam int unsigned LOOP_HI    = 16;
  localparam int unsigned CTRL_W     = 6;
  localparam int unsigned BURST_BIT  = 4;
  localparam int unsigned DIR_BIT    = 5;

  typedef enum logic [1:0] {
    F_ADDR = 2'd0,
    F_XLEN = 2'd1,
    F_YLEN = 2'd2,
    F_CTRL = 2'd3
  } ch_field_e;
endpackage

// File: rtl/dma_ch_regs.sv
module dma_ch_regs
  import dma_regbank_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              win_we_i,
  input  ch_field_e         field_i,
  input  logic              wid_we_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     addr_o,
  output logic [DW-1:0]     xlen_o,
  output logic [DW-1:0]     ylen_o,
  output logic [DW-1:0]     width_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              start_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      xlen_o  <= '0;
      ylen_o  <= '0;
      ctrl_o  <= '0;
      start_o <= 1'b0;
    end else begin
      start_o <= win_we_i && (field_i == F_ADDR);
      if (win_we_i) begin
        unique case (field_i)
          F_ADDR: addr_o <= wdata_i;
          F_XLEN: xlen_o <= wdata_i;
          F_YLEN: ylen_o <= wdata_i;
          F_CTRL: ctrl_o <= wdata_i[CTRL_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       width_o <= '0;
    else if (wid_we_i) width_o <= wdata_i;
  end

  p_addr_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_we_i && field_i == F_ADDR) |=> (start_o && addr_o == $past(wdata_i)));

  p_ctrl_mask_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_we_i && field_i == F_CTRL) |=> (ctrl_o == $past(wdata_i[CTRL_W-1:0])));

  p_width_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wid_we_i |=> (width_o == $past(wdata_i)));

endmodule

// File: rtl/dma_glb_regs.sv
module dma_glb_regs #(
  parameter int unsigned NUM_CH  = 16,
  parameter int unsigned DW      = 32,
  parameter int unsigned LOOP_HI = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_we_i,
  input  logic              sts_we_i,
  input  logic              en_we_i,
  input  logic              loop_we_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [NUM_CH-1:0] launch_i,
  input  logic [NUM_CH-1:0] done_i,
  output logic [NUM_CH-1:0] act_o,
  output logic [NUM_CH-1:0] sts_o,
  output logic [NUM_CH-1:0] en_o,
  output logic [DW-1:0]     loop_reg_o,
  output logic [NUM_CH-1:0] loop_o,
  output logic [NUM_CH-1:0] cancel_o,
  output logic              irq_o
);

  logic [NUM_CH-1:0] wmask, sts_clr, act_clr;

  assign wmask   = wdata_i[NUM_CH-1:0];
  assign sts_clr = sts_we_i ? wmask : '0;
  // a looping channel survives its own completion event
  assign act_clr = (valid_we_i ? wmask : '0) | (done_i & ~loop_o);

  for (genvar n = 0; n < NUM_CH; n++) begin : g_loop
    assign loop_o[n] = loop_reg_o[n] & loop_reg_o[n+LOOP_HI];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_o      <= '0;
      sts_o      <= '0;
      en_o       <= '0;
      loop_reg_o <= '0;
      cancel_o   <= '0;
    end else begin
      act_o    <= (act_o & ~act_clr) | launch_i;
      sts_o    <= (sts_o & ~sts_clr) | done_i;
      cancel_o <= valid_we_i ? wmask : '0;
      if (en_we_i)   en_o       <= wmask;
      if (loop_we_i) loop_reg_o <= wdata_i;
    end
  end

  assign irq_o = |(sts_o & en_o);

  p_sts_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(sts_o) & ~$past(sts_clr)) & ~sts_o) == '0));

  p_set_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(done_i) & ~sts_o) == '0));

  p_irq_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(|done_i) || $past(en_we_i)));

  p_cancel_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cancel_o & act_o & ~$past(launch_i)) == '0);

  p_loop_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_we_i && ((done_i & loop_o & act_o) != '0)) |=>
      (($past(done_i & loop_o & act_o) & ~act_o) == '0));

endmodule

// File: rtl/dma_regbank.sv
module dma_regbank
  import dma_regbank_pkg::*;
#(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned AW     = 12,
  parameter int unsigned DW     = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [DW-1:0]        wdata_i,
  output logic [DW-1:0]        rdata_o,
  input  logic [NUM_CH-1:0]    done_i,
  output logic [NUM_CH-1:0]    start_o,
  output logic [NUM_CH-1:0]    cancel_o,
  output logic [NUM_CH*DW-1:0] addr_o,
  output logic [NUM_CH*DW-1:0] xlen_o,
  output logic [NUM_CH*DW-1:0] ylen_o,
  output logic [NUM_CH*DW-1:0] width_o,
  output logic [NUM_CH-1:0]    burst4_o,
  output logic [NUM_CH-1:0]    dir_o,
  output logic [NUM_CH-1:0]    loop_o,
  output logic                 irq_o
);

  localparam int unsigned CHW     = $clog2(NUM_CH);
  localparam int unsigned CH_SPAN = NUM_CH * CH_STRIDE;
  localparam int unsigned WID_END = WIDTH_BASE + 4 * NUM_CH;

  logic                 aligned, in_chan, in_width;
  logic [CHW-1:0]       ch_idx, w_idx;
  ch_field_e            field;
  logic [NUM_CH-1:0]    win_we, wid_we, launch;
  logic [NUM_CH-1:0]    act, sts, en;
  logic [DW-1:0]        loop_reg;
  logic                 valid_we, sts_we, en_we, loop_we;

  logic [NUM_CH-1:0][DW-1:0]     addr_a, xlen_a, ylen_a, width_a;
  logic [NUM_CH-1:0][CTRL_W-1:0] ctrl_a;

  assign aligned  = (addr_i[1:0] == 2'b00);
  assign in_chan  = aligned && (addr_i < AW'(CH_SPAN));
  assign in_width = aligned && (addr_i >= AW'(WIDTH_BASE)) && (addr_i < AW'(WID_END));
  assign ch_idx   = addr_i[CHW+3:4];
  assign w_idx    = addr_i[CHW+1:2];
  assign field    = ch_field_e'(addr_i[3:2]);

  assign valid_we = wr_en_i && (addr_i == AW'(VALID_OFF));
  assign sts_we   = wr_en_i && (addr_i == AW'(STS_OFF));
  assign en_we    = wr_en_i && (addr_i == AW'(EN_OFF));
  assign loop_we  = wr_en_i && (addr_i == AW'(LOOP_OFF));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign win_we[c] = wr_en_i && in_chan && (ch_idx == CHW'(c));
    assign wid_we[c] = wr_en_i && in_width && (w_idx == CHW'(c));
    assign launch[c] = win_we[c] && (field == F_ADDR);

    dma_ch_regs #(.DW(DW)) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .win_we_i (win_we[c]),
      .field_i  (field),
      .wid_we_i (wid_we[c]),
      .wdata_i  (wdata_i),
      .addr_o   (addr_a[c]),
      .xlen_o   (xlen_a[c]),
      .ylen_o   (ylen_a[c]),
      .width_o  (width_a[c]),
      .ctrl_o   (ctrl_a[c]),
      .start_o  (start_o[c])
    );

    assign burst4_o[c] = ctrl_a[c][BURST_BIT];
    assign dir_o[c]    = ctrl_a[c][DIR_BIT];
  end

  assign addr_o  = addr_a;
  assign xlen_o  = xlen_a;
  assign ylen_o  = ylen_a;
  assign width_o = width_a;

  dma_glb_regs #(.NUM_CH(NUM_CH), .DW(DW), .LOOP_HI(LOOP_HI)) u_glb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_we_i (valid_we),
    .sts_we_i   (sts_we),
    .en_we_i    (en_we),
    .loop_we_i  (loop_we),
    .wdata_i    (wdata_i),
    .launch_i   (launch),
    .done_i     (done_i),
    .act_o      (act),
    .sts_o      (sts),
    .en_o       (en),
    .loop_reg_o (loop_reg),
    .loop_o     (loop_o),
    .cancel_o   (cancel_o),
    .irq_o      (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (in_chan) begin
      unique case (field)
        F_ADDR: rdata_o = addr_a[ch_idx];
        F_XLEN: rdata_o = xlen_a[ch_idx];
        F_YLEN: rdata_o = ylen_a[ch_idx];
        F_CTRL: rdata_o = DW'(ctrl_a[ch_idx]);
        default: rdata_o = '0;
      endcase
    end else if (in_width) begin
      rdata_o = width_a[w_idx];
    end else if (addr_i == AW'(VALID_OFF)) begin
      rdata_o = DW'(act);
    end else if (addr_i == AW'(STS_OFF)) begin
      rdata_o = DW'(sts);
    end else if (addr_i == AW'(EN_OFF)) begin
      rdata_o = DW'(en);
    end else if (addr_i == AW'(LOOP_OFF)) begin
      rdata_o = loop_reg;
    end
  end

  p_one_start_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(start_o));

  p_start_runs_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o & ~act) == '0);

  p_unmapped_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !aligned) |=> (start_o == '0 && cancel_o == '0));

endmodule

// File: tb/sim_dma_regbank.sv
module sim_dma_regbank;
  localparam int NCH = 16;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              wr_en = 1'b0;
  logic [11:0]       addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic [NCH-1:0]    done = '0;
  logic [NCH-1:0]    start, cancel, burst4, dir, loop_f;
  logic [NCH*32-1:0] addr_v, xlen_v, ylen_v, width_v;
  logic              irq;

  always #2 clk = ~clk;

  dma_regbank u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .done_i(done), .start_o(start),
    .cancel_o(cancel), .addr_o(addr_v), .xlen_o(xlen_v), .ylen_o(ylen_v),
    .width_o(width_v), .burst4_o(burst4), .dir_o(dir), .loop_o(loop_f),
    .irq_o(irq)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;

  logic [31:0]    m_addr[NCH], m_x[NCH], m_y[NCH], m_w[NCH];
  logic [5:0]     m_ctl[NCH];
  logic [NCH-1:0] m_act = '0, m_sts = '0, m_en = '0;
  logic [31:0]    m_loop = '0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [NCH-1:0] lp();
    return m_loop[15:0] & m_loop[31:16];
  endfunction

  function automatic logic [31:0] exp_rd(input logic [11:0] a);
    if (a[1:0] != 2'b00) return 32'h0;
    if (a < 12'h100) begin
      case (a[3:2])
        2'd0: return m_addr[a[7:4]];
        2'd1: return m_x[a[7:4]];
        2'd2: return m_y[a[7:4]];
        default: return {26'h0, m_ctl[a[7:4]]};
      endcase
    end
    if (a >= 12'h100 && a < 12'h140) return m_w[a[5:2]];
    case (a)
      12'h140: return {16'h0, m_act};
      12'h144: return {16'h0, m_sts};
      12'h148: return {16'h0, m_en};
      12'h150: return m_loop;
      default: return 32'h0;
    endcase
  endfunction

  // one bus cycle with optional write and completion events; checks pulses and irq
  task automatic step(input logic we, input logic [11:0] a, input logic [31:0] d,
                      input logic [NCH-1:0] dn);
    logic [NCH-1:0] lb, lau, exp_start, exp_cancel;
    @(negedge clk);
    wr_en = we; addr = a; wdata = d; done = dn;
    @(negedge clk);
    wr_en = 1'b0; done = '0;
    lb = lp();
    lau = '0;
    exp_cancel = '0;
    if (we && a[1:0] == 2'b00) begin
      if (a < 12'h100) begin
        case (a[3:2])
          2'd0: begin m_addr[a[7:4]] = d; lau[a[7:4]] = 1'b1; end
          2'd1: m_x[a[7:4]] = d;
          2'd2: m_y[a[7:4]] = d;
          default: m_ctl[a[7:4]] = d[5:0];
        endcase
      end else if (a < 12'h140) begin
        m_w[a[5:2]] = d;
      end else begin
        case (a)
          12'h140: begin m_act &= ~d[15:0]; exp_cancel = d[15:0]; end
          12'h144: m_sts &= ~d[15:0];
          12'h148: m_en = d[15:0];
          12'h150: m_loop = d;
          default: ;
        endcase
      end
    end
    m_sts |= dn;
    m_act = (m_act & ~(dn & ~lb)) | lau;
    exp_start = lau;
    chk("R5 start pulse", {16'h0, start}, {16'h0, exp_start});
    chk("R6 cancel pulse", {16'h0, cancel}, {16'h0, exp_cancel});
    chk("R8 irq", {31'h0, irq}, {31'h0, |(m_sts & m_en)});
  endtask

  task automatic rd(input string tag, input logic [11:0] a);
    addr = a;
    #1;
    chk(tag, rdata, exp_rd(a));
  endtask

  task automatic sweep();
    @(negedge clk);
    for (int c = 0; c < NCH; c++) begin
      rd("R2 addr rd", 12'(c * 16));
      rd("R2 xlen rd", 12'(c * 16 + 4));
      rd("R2 ylen rd", 12'(c * 16 + 8));
      rd("R2 ctrl rd", 12'(c * 16 + 12));
      rd("R4 width rd", 12'(12'h100 + c * 4));
      chk("R2 addr_o", addr_v[c*32 +: 32], m_addr[c]);
      chk("R2 xlen_o", xlen_v[c*32 +: 32], m_x[c]);
      chk("R2 ylen_o", ylen_v[c*32 +: 32], m_y[c]);
      chk("R4 width_o", width_v[c*32 +: 32], m_w[c]);
      chk("R3 burst4_o", {31'h0, burst4[c]}, {31'h0, m_ctl[c][4]});
      chk("R3 dir_o", {31'h0, dir[c]}, {31'h0, m_ctl[c][5]});
    end
    rd("R6 valid rd", 12'h140);
    rd("R7 status rd", 12'h144);
    rd("R8 enable rd", 12'h148);
    rd("R9 loop rd", 12'h150);
    chk("R9 loop_o", {16'h0, loop_f}, {16'h0, lp()});
    rd("R10 gap 14C", 12'h14C);
    rd("R10 gap 154", 12'h154);
    rd("R10 high", 12'h400);
    rd("R10 misaligned", 12'h105);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin
      m_addr[c] = '0; m_x[c] = '0; m_y[c] = '0; m_w[c] = '0; m_ctl[c] = '0;
    end
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    // R1 reset state
    rd("R1 reset addr", 12'h000);
    rd("R1 reset ctrl", 12'h0FC);
    rd("R1 reset loop", 12'h150);
    chk("R1 reset start", {16'h0, start}, 32'h0);
    chk("R1 reset irq", {31'h0, irq}, 32'h0);
    chk("R1 reset addr_o", addr_v[31:0], 32'h0);
    rst_ni = 1'b1;
    sweep();

    // R2/R3 program channel 3 before launching it
    step(1'b1, 12'h034, 32'h0000_0040, '0);
    step(1'b1, 12'h038, 32'h0000_0007, '0);
    step(1'b1, 12'h03C, 32'hFFFF_FFD0, '0);
    step(1'b1, 12'h10C, 32'h0000_0050, '0);
    step(1'b1, 12'h030, 32'h1234_5678, '0);
    sweep();

    // R10 writes to holes and misaligned offsets
    step(1'b1, 12'h14C, 32'hFFFF_FFFF, '0);
    step(1'b1, 12'h154, 32'hFFFF_FFFF, '0);
    step(1'b1, 12'h031, 32'hFFFF_FFFF, '0);
    step(1'b1, 12'h800, 32'hFFFF_FFFF, '0);
    sweep();

    // R7 set beats clear, R8 irq with enable
    step(1'b1, 12'h148, 32'h0000_0004, '0);
    step(1'b0, 12'h000, 32'h0, 16'h0004);
    step(1'b1, 12'h144, 32'h0000_0004, 16'h0004);
    rd("R7 set wins", 12'h144);
    step(1'b1, 12'h144, 32'h0000_0004, '0);
    rd("R7 clear", 12'h144);

    // R9 loop pair on channels 0 and 2, R6 completion/cancel
    step(1'b1, 12'h150, 32'h0005_0005, '0);
    step(1'b1, 12'h000, 32'hA000_0000, '0);
    step(1'b1, 12'h010, 32'hB000_0000, '0);
    step(1'b0, 12'h000, 32'h0, 16'h0003);
    rd("R9 loop keeps running", 12'h140);
    step(1'b1, 12'h140, 32'h0000_0009, '0);
    rd("R6 cancel clears", 12'h140);
    step(1'b1, 12'h020, 32'hC000_0000, 16'h0004);
    rd("R6 launch beats done", 12'h140);
    sweep();

    // constrained random traffic
    for (int i = 0; i < 600; i++) begin
      logic [11:0] a;
      logic [NCH-1:0] dn;
      logic we;
      int k;
      k = int'($urandom % 8);
      we = 1'b1;
      case (k)
        0, 1, 2, 3: a = {4'h0, 4'($urandom), 2'($urandom), 2'b00};
        4: a = 12'(12'h100 + ($urandom % 16) * 4);
        5: begin
          case ($urandom % 4)
            0: a = 12'h140;
            1: a = 12'h144;
            2: a = 12'h148;
            default: a = 12'h150;
          endcase
        end
        6: a = ($urandom % 2 == 0) ? 12'(12'h14C + 8 * ($urandom % 2)) : 12'($urandom);
        default: begin a = 12'h000; we = 1'b0; end
      endcase
      dn = ($urandom % 3 == 0) ? 16'($urandom & $urandom) : '0;
      step(we, a, $urandom, dn);
      if (i % 40 == 39) sweep();
    end
    sweep();

    summary();
    $finish;
  end
endmodule